// File: doc/BRIEF.md
# System Bus Access Master

This block lets an external debugger read and write memory on the system bus without involving a processor. The debugger sees three 32-bit registers through a small register port: a control/status word, an address word and a data word. Writing the data word starts a bus write. A bus read can start in two ways: when the address word is written, or when the data word is read, depending on two enable bits. The transfer size (byte, halfword, word) is chosen in the control word. An optional mode adds the transfer size in bytes to the address after each error-free access.

Before any request reaches the bus, the block checks the access. The checks cover the debug-enable code, a size that is too large, an address that is not aligned, an access that is still outstanding and sticky errors that have not been cleared. A failed check records a code in a sticky error field or sets a busy-error bit, and no request is issued. A bus response can report an error or an integrity error; an integrity error also pulses an alert output. There is no response timeout. The bus side is a valid/ready request channel and a response channel that is always accepted, because at most one request is ever outstanding.

Register port rules:
- The register port never applies back-pressure: `reg_req_ready` is tied high.
- Every accepted request returns `reg_rsp_valid` exactly one cycle later.

Bus rules:
- `bus_req_valid` stays asserted, with all request fields unchanged, until `bus_req_ready` is seen.
- A response is taken from `bus_rsp_valid` only while a request is outstanding.

Top module: `sba_master`

## Requirements
- R1: After reset the control, address and data registers read 0, `bus_req_valid` is low and `alert_o` is low.
- R2: `reg_req_ready` is always 1. A request accepted at a clock edge returns `reg_rsp_valid` and `reg_rdata` after that same edge. `reg_rdata` holds the register value from before the access. Register select: 0 = control, 1 = address, 2 = data. Control layout: bit 0 busy (read only), bit 1 busy-error, bits 4:2 error code, bits 7:5 size code (0 = 8, 1 = 16, 2 = 32 bits), bit 8 autoincrement, bit 9 read-on-address, bit 10 read-on-data.
- R3: A write of the data register stores the value and issues a bus write carrying the address register, that data and the size code. The busy bit reads 1 from that write until the response arrives.
- R4: With read-on-address set, a write of the address register issues a bus read at the new address. The response data, masked to the transfer size, lands in the data register.
- R5: With read-on-data set, a read of the data register returns the current value and then issues a bus read.
- R6: With autoincrement set, each access that completes without error adds 1, 2 or 4 (the transfer size in bytes) to the address register.
- R7: A size code above 2 sets the error field to 4 and issues no request.
- R8: An address that is not a multiple of the transfer size sets the error field to 3 and issues no request.
- R9: A response with the error flag set puts 2 in the error field.
- R10: A response with the integrity-error flag set puts 7 in the error field and raises `alert_o` for exactly one cycle.
- R11: While busy, a write of the address or data register, or a data read that would trigger, sets busy-error, is dropped, and issues no request.
- R12: The error field and busy-error are sticky and cleared by writing 1 to their bits. While either is nonzero, no request is issued.
- R13: While `lc_dbg_en` differs from the enable code `LC_ON` (default 4'b0101), no request is issued and busy stays 0.
- R14: `bus_req_valid` stays high with stable address, data, size and write flag until `bus_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_dbg_en | input | LC_W | Debug enable code; only LC_ON allows bus requests |
| reg_req_valid | input | 1 | Register port request valid |
| reg_req_ready | output | 1 | Register port ready, always 1 |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write when 1, read when 0 |
| reg_wdata | input | DW | Register write data |
| reg_rsp_valid | output | 1 | Register response valid |
| reg_rdata | output | DW | Register read data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_size | output | 2 | Bus size code |
| bus_we | output | 1 | Bus write flag |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rdata | input | DW | Bus read data, right-justified |
| bus_rsp_err | input | 1 | Bus response error |
| bus_rsp_intg_err | input | 1 | Bus response integrity error |
| alert_o | output | 1 | One-cycle alert on integrity error |

## Verification
Register read-back is the main lens. A wrong check order or a lost sticky code shows in the very next control-register read. A wrong address step shows in the next address read after the response. A request that should have been blocked shows at the bus port as an extra handshake within one cycle of the register access. The bus responder in the bench confirms this by comparing its request count. A corrupted request hold shows as changed fields while the responder withholds ready.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } sba_sel_e;

  typedef enum logic [2:0] {
    V_GO,
    V_BUSY,
    V_HOLD,
    V_SIZE,
    V_ALIGN,
    V_OFF
  } sba_verdict_e;

  localparam logic [2:0] ERR_BUS   = 3'd2;
  localparam logic [2:0] ERR_ALIGN = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;
  localparam logic [2:0] ERR_INTG  = 3'd7;

  localparam int CB_BUSY   = 0;
  localparam int CB_BERR   = 1;
  localparam int CB_ERR_LO = 2;
  localparam int CB_SZ_LO  = 5;
  localparam int CB_AINC   = 8;
  localparam int CB_RDADDR = 9;
  localparam int CB_RDDATA = 10;
endpackage

// File: rtl/sba_access_check.sv
module sba_access_check
  import sba_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LC_W   = 4,
  parameter logic [LC_W-1:0] LC_ON = 4'b0101,
  parameter int MAX_SZ = 2
) (
  input  logic            touch,
  input  logic            busy,
  input  logic [2:0]      err_q,
  input  logic            busy_err_q,
  input  logic [2:0]      size,
  input  logic [AW-1:0]   addr,
  input  logic [LC_W-1:0] lc_dbg_en,
  output sba_verdict_e    verdict
);
  logic [AW-1:0] low_mask;
  logic          misaligned;

  always_comb begin
    low_mask   = (AW'(1) << size) - AW'(1);
    misaligned = (addr & low_mask) != '0;
  end

  always_comb begin
    if (touch && busy)                      verdict = V_BUSY;
    else if (err_q != '0 || busy_err_q)     verdict = V_HOLD;
    else if (int'(size) > MAX_SZ)           verdict = V_SIZE;
    else if (misaligned)                    verdict = V_ALIGN;
    else if (lc_dbg_en != LC_ON)            verdict = V_OFF;
    else                                    verdict = V_GO;
  end
endmodule

// File: rtl/sba_bus_port.sv
module sba_bus_port #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int MAX_SZ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic [1:0]    l_size,
  input  logic          l_we,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [1:0]    bus_size,
  output logic          bus_we,
  input  logic          bus_rsp_valid,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rsp_err,
  input  logic          bus_rsp_intg_err,
  output logic          busy,
  output logic          done,
  output logic          done_err,
  output logic          done_intg,
  output logic [DW-1:0] done_rdata,
  output logic          alert_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;
  st_e  st_q;
  logic alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_size  <= '0;
      bus_we    <= 1'b0;
      alert_q   <= 1'b0;
    end else begin
      alert_q <= done && bus_rsp_intg_err;
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q      <= ST_REQ;
          bus_addr  <= l_addr;
          bus_wdata <= l_wdata;
          bus_size  <= l_size;
          bus_we    <= l_we;
        end
        ST_REQ:  if (bus_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (bus_rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_valid = (st_q == ST_REQ);
    busy          = (st_q != ST_IDLE);
    done          = (st_q == ST_WAIT) && bus_rsp_valid;
    done_err      = bus_rsp_err;
    done_intg     = bus_rsp_intg_err;
    done_rdata    = bus_rdata;
    alert_o       = alert_q;
  end

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_addr)
      && $stable(bus_wdata) && $stable(bus_size) && $stable(bus_we));
  // R8
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> (bus_addr & ((AW'(1) << bus_size) - AW'(1))) == '0);
  // R7
  req_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> int'(bus_size) <= MAX_SZ);
  // R10
  alert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |=> !alert_o);
  // R11
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/sba_regs.sv
module sba_regs
  import sba_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_req_valid,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic          reg_rsp_valid,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  sba_verdict_e  verdict,
  input  logic          done,
  input  logic          done_err,
  input  logic          done_intg,
  input  logic [DW-1:0] done_rdata,
  input  logic          done_we,
  input  logic [1:0]    done_size,
  output logic          touch,
  output logic [AW-1:0] chk_addr,
  output logic [2:0]    size_q,
  output logic [2:0]    err_q,
  output logic          busy_err_q,
  output logic          launch,
  output logic          launch_we,
  output logic [DW-1:0] launch_wdata
);
  logic          ainc_q, rdaddr_q, rddata_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          wr_ctrl, wr_addr, wr_data, rd_data, access;
  logic [DW-1:0] ctrl_word, rd_mask;

  always_comb begin
    wr_ctrl = reg_req_valid && reg_we && (reg_sel == SEL_CTRL);
    wr_addr = reg_req_valid && reg_we && (reg_sel == SEL_ADDR);
    wr_data = reg_req_valid && reg_we && (reg_sel == SEL_DATA);
    rd_data = reg_req_valid && !reg_we && (reg_sel == SEL_DATA);
    access  = wr_data || (wr_addr && rdaddr_q) || (rd_data && rddata_q);
    touch   = wr_addr || wr_data || (rd_data && rddata_q);
    chk_addr     = wr_addr ? reg_wdata[AW-1:0] : addr_q;
    launch       = access && (verdict == V_GO);
    launch_we    = wr_data;
    launch_wdata = reg_wdata;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_BUSY]                = busy;
    ctrl_word[CB_BERR]                = busy_err_q;
    ctrl_word[CB_ERR_LO +: 3]         = err_q;
    ctrl_word[CB_SZ_LO +: 3]          = size_q;
    ctrl_word[CB_AINC]                = ainc_q;
    ctrl_word[CB_RDADDR]              = rdaddr_q;
    ctrl_word[CB_RDDATA]              = rddata_q;
  end

  always_comb begin
    rd_mask = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < (8 << done_size)) rd_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rsp_valid <= 1'b0;
      reg_rdata     <= '0;
    end else begin
      reg_rsp_valid <= reg_req_valid;
      if (reg_req_valid) begin
        case (reg_sel)
          SEL_CTRL: reg_rdata <= ctrl_word;
          SEL_ADDR: reg_rdata <= DW'(addr_q);
          SEL_DATA: reg_rdata <= data_q;
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q     <= '0;
      ainc_q     <= 1'b0;
      rdaddr_q   <= 1'b0;
      rddata_q   <= 1'b0;
      err_q      <= '0;
      busy_err_q <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        size_q     <= reg_wdata[CB_SZ_LO +: 3];
        ainc_q     <= reg_wdata[CB_AINC];
        rdaddr_q   <= reg_wdata[CB_RDADDR];
        rddata_q   <= reg_wdata[CB_RDDATA];
        err_q      <= err_q & ~reg_wdata[CB_ERR_LO +: 3];
        busy_err_q <= busy_err_q & ~reg_wdata[CB_BERR];
      end
      if (touch && verdict == V_BUSY) busy_err_q <= 1'b1;
      if (wr_addr && !busy) addr_q <= reg_wdata[AW-1:0];
      if (wr_data && !busy) data_q <= reg_wdata;
      if (access && verdict == V_SIZE)  err_q <= ERR_SIZE;
      if (access && verdict == V_ALIGN) err_q <= ERR_ALIGN;
      if (done) begin
        if (done_intg)     err_q <= ERR_INTG;
        else if (done_err) err_q <= ERR_BUS;
        else begin
          if (!done_we) data_q <= done_rdata & rd_mask;
          if (ainc_q)   addr_q <= addr_q + (AW'(1) << done_size);
        end
      end
    end
  end

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q != '0 && !wr_ctrl |=> err_q != '0);
  // R11
  busy_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err_q) |-> $past(busy));
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid |=> reg_rsp_valid);
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LC_W = 4,
  parameter logic [LC_W-1:0] LC_ON = 4'b0101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LC_W-1:0] lc_dbg_en,
  input  logic            reg_req_valid,
  output logic            reg_req_ready,
  input  logic [1:0]      reg_sel,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic            reg_rsp_valid,
  output logic [DW-1:0]   reg_rdata,
  output logic            bus_req_valid,
  input  logic            bus_req_ready,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [1:0]      bus_size,
  output logic            bus_we,
  input  logic            bus_rsp_valid,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rsp_err,
  input  logic            bus_rsp_intg_err,
  output logic            alert_o
);
  localparam int MAX_SZ = $clog2(DW / 8);

  logic          busy, touch, busy_err_q, launch, launch_we;
  logic          done, done_err, done_intg;
  logic [AW-1:0] chk_addr;
  logic [2:0]    size_q, err_q;
  logic [DW-1:0] launch_wdata, done_rdata;
  sba_verdict_e  verdict;

  assign reg_req_ready = 1'b1;

  sba_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk, .rst_n, .reg_req_valid, .reg_sel, .reg_we, .reg_wdata,
    .reg_rsp_valid, .reg_rdata, .busy, .verdict, .done, .done_err,
    .done_intg, .done_rdata, .done_we(bus_we), .done_size(bus_size),
    .touch, .chk_addr, .size_q, .err_q, .busy_err_q, .launch,
    .launch_we, .launch_wdata
  );

  sba_access_check #(.AW(AW), .LC_W(LC_W), .LC_ON(LC_ON), .MAX_SZ(MAX_SZ)) u_check (
    .touch, .busy, .err_q, .busy_err_q, .size(size_q), .addr(chk_addr),
    .lc_dbg_en, .verdict
  );

  sba_bus_port #(.AW(AW), .DW(DW), .MAX_SZ(MAX_SZ)) u_port (
    .clk, .rst_n, .launch, .l_addr(chk_addr), .l_wdata(launch_wdata),
    .l_size(size_q[1:0]), .l_we(launch_we), .bus_req_valid, .bus_req_ready,
    .bus_addr, .bus_wdata, .bus_size, .bus_we, .bus_rsp_valid, .bus_rdata,
    .bus_rsp_err, .bus_rsp_intg_err, .busy, .done, .done_err, .done_intg,
    .done_rdata, .alert_o
  );

  // R13
  lc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) |-> $past(lc_dbg_en) == LC_ON);
endmodule

// File: tb/sba_master_bench.sv
`timescale 1ns/1ps
module sba_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lc_dbg_en = 4'b0101;
  logic        reg_req_valid = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_req_ready, reg_rsp_valid;
  logic [31:0] reg_rdata;
  logic        bus_req_valid, bus_we, alert_o;
  logic        bus_req_ready = 1'b0, bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0, bus_rsp_intg_err = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [1:0]  bus_size;

  sba_master u_sba_master (
    .clk, .rst_n, .lc_dbg_en, .reg_req_valid, .reg_req_ready, .reg_sel,
    .reg_we, .reg_wdata, .reg_rsp_valid, .reg_rdata, .bus_req_valid,
    .bus_req_ready, .bus_addr, .bus_wdata, .bus_size, .bus_we,
    .bus_rsp_valid, .bus_rdata, .bus_rsp_err, .bus_rsp_intg_err, .alert_o
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int req_count = 0, alert_count = 0, hold_bad = 0;
  int rsp_delay = 2, ready_delay = 0;
  bit inj_err = 0, inj_intg = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [1:0]  cap_size;
  logic        cap_we;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder: drives at negedges only
  initial begin
    bit pending = 0;
    int cnt = 0, hold_n = 0;
    logic [68:0] seen = '0;
    forever begin
      @(negedge clk);
      bus_req_ready = 0; bus_rsp_valid = 0; bus_rsp_err = 0; bus_rsp_intg_err = 0;
      if (pending) begin
        if (cnt == 0) begin
          bus_rsp_valid = 1;
          bus_rdata = 32'h89AB_0000 | {16'h0, cap_addr[15:0]};
          bus_rsp_err = inj_err;
          bus_rsp_intg_err = inj_intg;
          pending = 0;
        end else cnt--;
      end else if (bus_req_valid) begin
        if (hold_n > 0 && seen != {bus_addr, bus_wdata, bus_size, bus_we, 2'b0}) hold_bad++;
        seen = {bus_addr, bus_wdata, bus_size, bus_we, 2'b0};
        if (hold_n < ready_delay) hold_n++;
        else begin
          bus_req_ready = 1;
          cap_addr = bus_addr; cap_wdata = bus_wdata; cap_size = bus_size; cap_we = bus_we;
          req_count++;
          pending = 1; cnt = rsp_delay; hold_n = 0;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (alert_o) alert_count++;
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    reg_req_valid = 1; reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_req_valid = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
    reg_req_valid = 1; reg_we = 0; reg_sel = sel;
    @(posedge clk); @(negedge clk);
    d = reg_rsp_valid ? reg_rdata : 32'hxxxx_xxxx;
    reg_req_valid = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 100; i++) begin
      reg_rd(2'd0, c);
      if (c[0] == 1'b0) break;
    end
  endtask

  // {req[3:0], kind[1:0] (0 write, 1 read-check, 2 wait), sel[1:0], value, expected}
  localparam int NV = 24;
  localparam logic [71:0] VEC [NV] = '{
    {4'd2, 2'd0, 2'd0, 32'h0000_0040, 32'h0},          // R2 size word
    {4'd2, 2'd1, 2'd0, 32'h0,         32'h0000_0040},
    {4'd2, 2'd0, 2'd1, 32'h0000_0100, 32'h0},
    {4'd2, 2'd1, 2'd1, 32'h0,         32'h0000_0100},
    {4'd3, 2'd0, 2'd2, 32'hDEAD_BEEF, 32'h0},          // R3 write
    {4'd3, 2'd2, 2'd0, 32'h0,         32'h0},
    {4'd3, 2'd1, 2'd0, 32'h0,         32'h0000_0040},
    {4'd3, 2'd1, 2'd2, 32'h0,         32'hDEAD_BEEF},
    {4'd4, 2'd0, 2'd0, 32'h0000_0240, 32'h0},          // R4 read on address
    {4'd4, 2'd0, 2'd1, 32'h0000_0200, 32'h0},
    {4'd4, 2'd2, 2'd0, 32'h0,         32'h0},
    {4'd4, 2'd1, 2'd2, 32'h0,         32'h89AB_0200},
    {4'd6, 2'd0, 2'd0, 32'h0000_0300, 32'h0},          // R6 byte + autoinc
    {4'd6, 2'd0, 2'd1, 32'h0000_0013, 32'h0},
    {4'd6, 2'd2, 2'd0, 32'h0,         32'h0},
    {4'd4, 2'd1, 2'd2, 32'h0,         32'h0000_0013},
    {4'd6, 2'd1, 2'd1, 32'h0,         32'h0000_0014},
    {4'd5, 2'd0, 2'd0, 32'h0000_0520, 32'h0},          // R5 read on data
    {4'd5, 2'd0, 2'd1, 32'h0000_0020, 32'h0},
    {4'd5, 2'd1, 2'd2, 32'h0,         32'h0000_0013},
    {4'd5, 2'd2, 2'd0, 32'h0,         32'h0},
    {4'd5, 2'd1, 2'd2, 32'h0,         32'h0000_0020},
    {4'd5, 2'd2, 2'd0, 32'h0,         32'h0},
    {4'd6, 2'd1, 2'd1, 32'h0,         32'h0000_0024}
  };

  initial begin
    #200_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(bus_req_valid == 0 && alert_o == 0, "R1 outputs", {30'h0, bus_req_valid, alert_o}, 32'h0);
    check(reg_req_ready == 1, "R2 ready", {31'h0, reg_req_ready}, 32'h1);
    reg_rd(2'd0, v); check(v == 32'h0, "R1 ctrl", v, 32'h0);
    reg_rd(2'd1, v); check(v == 32'h0, "R1 addr", v, 32'h0);
    reg_rd(2'd2, v); check(v == 32'h0, "R1 data", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][67:66])
        2'd0: reg_wr(VEC[i][65:64], VEC[i][63:32]);
        2'd1: begin
          reg_rd(VEC[i][65:64], v);
          check(v == VEC[i][31:0], $sformatf("R%0d row %0d", VEC[i][71:68], i), v, VEC[i][31:0]);
        end
        default: wait_idle();
      endcase
    end
    // R5 last triggered read went to 0x22 as a halfword read
    check(cap_addr == 32'h22 && cap_we == 0 && cap_size == 2'd1, "R5 bus read fields",
          cap_addr, 32'h22);

    // R3 bus write fields at halfword size
    reg_wr(2'd0, 32'h20);
    reg_wr(2'd1, 32'h44);
    reg_wr(2'd2, 32'h1234);
    wait_idle();
    check(cap_addr == 32'h44 && cap_wdata == 32'h1234 && cap_size == 2'd1 && cap_we == 1,
          "R3 bus write fields", cap_wdata, 32'h1234);

    // R14 request held while ready withheld
    ready_delay = 3; n0 = req_count;
    reg_wr(2'd2, 32'h5678);
    wait_idle();
    ready_delay = 0;
    check(hold_bad == 0 && req_count == n0 + 1, "R14 hold", hold_bad, 32'h0);

    // R11 busy error, dropped writes, busy bit visible (R3)
    rsp_delay = 8;
    reg_wr(2'd0, 32'h40);
    reg_wr(2'd1, 32'h40);
    n0 = req_count;
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd0, v); check(v == 32'h41, "R3 busy bit", v, 32'h41);
    reg_wr(2'd2, 32'h2);
    reg_wr(2'd1, 32'h80);
    wait_idle();
    rsp_delay = 2;
    reg_rd(2'd0, v); check(v == 32'h42, "R11 busy error", v, 32'h42);
    reg_rd(2'd1, v); check(v == 32'h40, "R11 addr dropped", v, 32'h40);
    reg_rd(2'd2, v); check(v == 32'h1, "R11 data dropped", v, 32'h1);
    check(req_count == n0 + 1, "R11 one request", req_count, n0 + 1);
    reg_wr(2'd0, 32'h42);
    reg_rd(2'd0, v); check(v == 32'h40, "R12 busy error clear", v, 32'h40);

    // R7 size error then R12 suppression
    n0 = req_count;
    reg_wr(2'd0, 32'h60);
    reg_wr(2'd2, 32'h9);
    reg_rd(2'd0, v); check(v == 32'h70, "R7 size error", v, 32'h70);
    reg_wr(2'd0, 32'h40);
    reg_rd(2'd0, v); check(v == 32'h50, "R12 sticky", v, 32'h50);
    reg_wr(2'd2, 32'hA);
    repeat (4) @(negedge clk);
    check(req_count == n0, "R12 suppressed", req_count, n0);
    reg_wr(2'd0, 32'h5C);
    reg_rd(2'd0, v); check(v == 32'h40, "R12 clear", v, 32'h40);

    // R8 misalignment
    reg_wr(2'd1, 32'h42);
    reg_wr(2'd2, 32'hB);
    repeat (4) @(negedge clk);
    reg_rd(2'd0, v); check(v == 32'h4C, "R8 align error", v, 32'h4C);
    check(req_count == n0, "R8 no request", req_count, n0);
    reg_wr(2'd0, 32'h5C);

    // R9 response error
    reg_wr(2'd1, 32'h40);
    inj_err = 1;
    reg_wr(2'd2, 32'hC);
    wait_idle();
    inj_err = 0;
    reg_rd(2'd0, v); check(v == 32'h48, "R9 bus error", v, 32'h48);
    reg_wr(2'd0, 32'h5C);

    // R10 integrity error and alert
    inj_intg = 1;
    reg_wr(2'd2, 32'hD);
    wait_idle();
    inj_intg = 0;
    repeat (2) @(negedge clk);
    reg_rd(2'd0, v); check(v == 32'h5C, "R10 intg error", v, 32'h5C);
    check(alert_count == 1, "R10 alert pulse", alert_count, 1);
    reg_wr(2'd0, 32'h5C);

    // R13 debug disabled
    lc_dbg_en = 4'b0100; n0 = req_count;
    reg_wr(2'd2, 32'hE);
    reg_rd(2'd0, v); check(v == 32'h40, "R13 no busy", v, 32'h40);
    repeat (4) @(negedge clk);
    check(req_count == n0, "R13 no request", req_count, n0);
    lc_dbg_en = 4'b0101;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule